// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands of `W` bits each over several clock cycles and returns a signed product of `2W` bits. A one-cycle start request loads the operands. The block then performs one recoding step per cycle for `W` cycles. In each step it examines the low bit of the multiplier register together with the bit shifted out in the previous step.

Each step takes one of three actions on the partial product. When the low bit is 1 and the previous bit is 0, the step subtracts the multiplicand, because this marks the beginning of a run of ones. When the low bit is 0 and the previous bit is 1, the step adds the multiplicand, because the run has just ended. When the two bits match, the partial product is left as it is. After the action, the whole chain of accumulator, multiplier register and previous bit shifts right by one place, and the sign of the accumulator is copied in at the top. A run of ones from bit q up to bit p therefore contributes 2^(p+1) − 2^q times the multiplicand. For example, a multiplier of 14 costs one subtract at weight 2 and one add at weight 16.

The accumulator is one bit wider than an operand. This extra bit keeps the intermediate sum exact when the most negative multiplicand is subtracted. When the last step completes, `done_o` pulses for one cycle. The product stays on the output until the next accepted start.

Top module: `booth_mult`

## Requirements
- R1: After a synchronous active-low reset, `busy_o` is 0, `done_o` is 0 and `product_o` is 0.
- R2: A `start_i` high while `busy_o` is 0 is accepted. `busy_o` is 1 in the cycle after the accepting edge.
- R3: An accepted start leaves `busy_o` high for exactly `W` cycles. `done_o` is high in the cycle that follows the last busy cycle.
- R4: `done_o` is high for one cycle only per accepted start, and `busy_o` is 0 while `done_o` is high.
- R5: When `done_o` is high, `product_o` equals the signed product, `2W` bits wide, of the two operands that were sampled at the accepting edge. This holds for every sign combination.
- R6: The most negative value times the most negative value gives +2^(2W−2). The most negative value times the most positive value gives the correct negative product.
- R7: Multipliers that contain runs of ones give correct products: alternating bit patterns, all ones, a single inner run such as 14, and zero. This covers the subtract, add and no-action cases of the recoding.
- R8: While `busy_o` is 1, `start_i`, `mcand_i` and `mplier_i` are ignored. The pending result and its timing do not change.
- R9: While the block is idle and no start is accepted, `product_o` holds its last value.
- R10: A start presented in the same cycle that `done_o` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to begin a multiplication |
| mcand_i | input | W | Signed multiplicand |
| mplier_i | input | W | Signed multiplier |
| busy_o | output | 1 | A multiplication is in progress |
| done_o | output | 1 | One-cycle pulse when the product is ready |
| product_o | output | 2W | Signed product |

## Verification
The checker takes for granted that the operands seen at the accepting edge are the ones the user wants multiplied. It keeps its own copy of those operands and does not re-sample the inputs while the block is busy. Its latency and product checks also assume that reset is not asserted in the middle of an operation. The directed bench only drives operands together with an accepted start and never applies reset during an operation. The deliberate changes the bench makes to the inputs while the block is busy are exactly the ones R8 says must be ignored.

// File: rtl/booth_mult_pkg.sv
// Shared types for the sequential Booth multiplier.
// Assumes: nothing beyond IEEE 1800-2017.
package booth_mult_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } booth_op_e;
endpackage

// File: rtl/booth_recode.sv
// Radix-2 Booth recoder: chooses the action for one step from the current
// multiplier low bit and the bit shifted out in the previous step.
// Assumes: the previous bit is 0 before the first step.
module booth_recode
    import booth_mult_pkg::*;
(
    input  logic      cur_bit_i,
    input  logic      prev_bit_i,
    output booth_op_e op_o
);
    // Map the bit pair to add, subtract or hold.
    always_comb begin
        unique case ({cur_bit_i, prev_bit_i})
            2'b10:   op_o = OP_SUB;
            2'b01:   op_o = OP_ADD;
            default: op_o = OP_HOLD;
        endcase
    end
endmodule

// File: rtl/booth_step.sv
// One Booth step: adds, subtracts or keeps the multiplicand in the
// accumulator, then shifts {acc, mreg, prev} one place right arithmetically.
// Assumes: the accumulator is one bit wider than an operand, so the sum of a
// sign-extended multiplicand and the accumulator never wraps.
module booth_step
    import booth_mult_pkg::*;
#(
    parameter int W = 8
) (
    input  booth_op_e       op_i,
    input  logic [W:0]      acc_i,
    input  logic [W-1:0]    mreg_i,
    input  logic [W-1:0]    mcand_i,
    output logic [W:0]      acc_o,
    output logic [W-1:0]    mreg_o,
    output logic            prev_o
);
    localparam int AW = W + 1;

    logic [AW-1:0] mcand_ext;
    logic [AW-1:0] sum;

    // Sign-extend the multiplicand to accumulator width.
    always_comb mcand_ext = {mcand_i[W-1], mcand_i};

    // Apply the recoded action to the partial product.
    always_comb begin
        unique case (op_i)
            OP_ADD:  sum = acc_i + mcand_ext;
            OP_SUB:  sum = acc_i - mcand_ext;
            default: sum = acc_i;
        endcase
    end

    // Arithmetic right shift across accumulator, multiplier register, prev bit.
    always_comb begin
        acc_o  = {sum[AW-1], sum[AW-1:1]};
        mreg_o = {sum[0], mreg_i[W-1:1]};
        prev_o = mreg_i[0];
    end
endmodule

// File: rtl/booth_ctrl.sv
// Sequencer: accepts a start when idle, runs W steps with a down-counter,
// then raises a one-cycle done pulse.
// Assumes: synchronous active-low reset; start is ignored while busy.
module booth_ctrl #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] steps_left;

    // Accept a start only when no operation is in progress.
    always_comb load_o = start_i && !busy_o;
    // Every busy cycle performs one step.
    always_comb step_o = busy_o;

    // Count down the steps and generate busy and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            steps_left <= '0;
            busy_o     <= 1'b0;
            done_o     <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (load_o) begin
                steps_left <= CW'(W);
                busy_o     <= 1'b1;
            end else if (busy_o) begin
                steps_left <= steps_left - 1'b1;
                if (steps_left == CW'(1)) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/booth_mult.sv
// Sequential radix-2 Booth multiplier for signed operands of W bits,
// producing a 2W-bit signed product after W step cycles.
// Assumes: operands are sampled only on an accepted start; the product
// register holds its value until the next accepted start.
module booth_mult
    import booth_mult_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [W-1:0]     mcand_i,
    input  logic [W-1:0]     mplier_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [2*W-1:0]   product_o
);
    logic [W:0]   acc_q;
    logic [W-1:0] mreg_q;
    logic         prev_q;
    logic [W-1:0] mcand_q;

    logic [W:0]   acc_d;
    logic [W-1:0] mreg_d;
    logic         prev_d;
    booth_op_e    op;
    logic         load;
    logic         step;

    booth_ctrl #(.W(W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    booth_recode u_recode (
        .cur_bit_i  (mreg_q[0]),
        .prev_bit_i (prev_q),
        .op_o       (op)
    );

    booth_step #(.W(W)) u_step (
        .op_i    (op),
        .acc_i   (acc_q),
        .mreg_i  (mreg_q),
        .mcand_i (mcand_q),
        .acc_o   (acc_d),
        .mreg_o  (mreg_d),
        .prev_o  (prev_d)
    );

    // Load operands on start, advance one Booth step per busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            mreg_q  <= '0;
            prev_q  <= 1'b0;
            mcand_q <= '0;
        end else if (load) begin
            acc_q   <= '0;
            mreg_q  <= mplier_i;
            prev_q  <= 1'b0;
            mcand_q <= mcand_i;
        end else if (step) begin
            acc_q  <= acc_d;
            mreg_q <= mreg_d;
            prev_q <= prev_d;
        end
    end

    // The product is the low 2W bits of the accumulator-multiplier chain.
    always_comb product_o = {acc_q[W-1:0], mreg_q};
endmodule

// File: rtl/booth_mult_chk.sv
// Protocol and result checker for booth_mult, attached by bind.
// Assumes: reset is not asserted in the middle of an operation.
module booth_mult_chk #(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start_i,
    input logic [W-1:0]   mcand_i,
    input logic [W-1:0]   mplier_i,
    input logic           busy_o,
    input logic           done_o,
    input logic [2*W-1:0] product_o
);
    logic signed [W-1:0]   a_cap;
    logic signed [W-1:0]   b_cap;
    logic signed [2*W-1:0] exp_prod;
    int unsigned           busy_cycles;

    // Capture the accepted operands and count the busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_cap       <= '0;
            b_cap       <= '0;
            busy_cycles <= 0;
        end else if (start_i && !busy_o) begin
            a_cap       <= mcand_i;
            b_cap       <= mplier_i;
            busy_cycles <= 0;
        end else if (busy_o) begin
            busy_cycles <= busy_cycles + 1;
        end
    end

    // Reference product, computed at double width.
    always_comb exp_prod = (2*W)'(a_cap) * (2*W)'(b_cap);

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R2
    AST_DONE_AFTER_W: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_cycles == W)); // R3
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R4
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R4
    AST_PRODUCT_OK: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (product_o == exp_prod)); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(product_o)); // R9
endmodule

bind booth_mult booth_mult_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .product_o (product_o)
);

// File: tb/booth_mult_test.sv
// Directed bench for booth_mult: one task per scenario, each self-checking.
module booth_mult_test;
    localparam int W  = 8;
    localparam int PW = 2 * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [W-1:0]  mcand_i = '0;
    logic [W-1:0]  mplier_i = '0;
    logic          busy_o;
    logic          done_o;
    logic [PW-1:0] product_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    booth_mult #(.W(W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .mcand_i   (mcand_i),
        .mplier_i  (mplier_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .product_o (product_o)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        logic signed [PW-1:0] r;
        r = PW'($signed(a)) * PW'($signed(b));
        return r;
    endfunction

    // Issue a start at the current negedge, wait for done, check latency and product.
    // With poke set, inputs are disturbed while busy (R8).
    task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                           input string req, input bit poke);
        int cyc;
        mcand_i  = a;
        mplier_i = b;
        start_i  = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R2", "busy after start", longint'(busy_o), 1);
        cyc = 0;
        while (!done_o && cyc < 4 * W) begin
            if (poke) begin
                start_i  = 1'b1;
                mcand_i  = ~a;
                mplier_i = b + 8'd3;
            end
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        check(cyc == W, req, "cycles to done", cyc, W);
        check(busy_o == 1'b0, "R4", "busy low with done", longint'(busy_o), 0);
        check(product_o == ref_mul(a, b), req, "product",
              longint'($signed(product_o)), longint'($signed(ref_mul(a, b))));
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(busy_o == 1'b0 && done_o == 1'b0, "R1", "busy/done at reset",
              longint'({busy_o, done_o}), 0);
        check(product_o == '0, "R1", "product at reset", longint'(product_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_basic;
        run_mul(8'd3, 8'd5, "R5", 1'b0);
        run_mul(8'hF9, 8'd6, "R5", 1'b0);   // -7 * 6
        run_mul(8'd6, 8'hF9, "R5", 1'b0);   // 6 * -7
        run_mul(8'hF3, 8'hEE, "R5", 1'b0);  // -13 * -18
    endtask

    task automatic t_runs;
        run_mul(8'hFD, 8'd14, "R7", 1'b0);  // -3 * 14, one inner run
        run_mul(8'd37, 8'h55, "R7", 1'b0);  // alternating bits
        run_mul(8'd37, 8'hAA, "R7", 1'b0);  // alternating, negative
        run_mul(8'd91, 8'hFF, "R7", 1'b0);  // all ones
        run_mul(8'd91, 8'h00, "R7", 1'b0);  // zero multiplier
        run_mul(8'h7F, 8'h7E, "R7", 1'b0);  // long run below sign
    endtask

    task automatic t_extremes;
        run_mul(8'h80, 8'h80, "R6", 1'b0);
        check(product_o == 16'h4000, "R6", "min*min", longint'(product_o), 16'h4000);
        run_mul(8'h80, 8'h7F, "R6", 1'b0);
        run_mul(8'h7F, 8'h80, "R6", 1'b0);
        run_mul(8'h7F, 8'h7F, "R6", 1'b0);
    endtask

    task automatic t_done_pulse;
        run_mul(8'd9, 8'd11, "R3", 1'b0);
        @(negedge clk);
        check(done_o == 1'b0, "R4", "done next cycle", longint'(done_o), 0);
    endtask

    task automatic t_ignore_busy;
        run_mul(8'd23, 8'hE5, "R8", 1'b1);
        @(negedge clk);
        check(busy_o == 1'b0 && done_o == 1'b0, "R8", "no extra op started",
              longint'({busy_o, done_o}), 0);
    endtask

    task automatic t_hold;
        logic [PW-1:0] held;
        run_mul(8'hC4, 8'd19, "R9", 1'b0);
        held = product_o;
        for (int i = 0; i < 6; i++) begin
            mcand_i  = 8'(i * 29);
            mplier_i = 8'(i * 53 + 1);
            @(negedge clk);
        end
        check(product_o == held, "R9", "product held while idle",
              longint'(product_o), longint'(held));
        check(busy_o == 1'b0, "R9", "stays idle", longint'(busy_o), 0);
    endtask

    task automatic t_back_to_back;
        run_mul(8'd12, 8'd10, "R10", 1'b0);
        run_mul(8'hEC, 8'd7, "R10", 1'b0);  // start in the done cycle
    endtask

    initial begin
        t_reset();
        t_basic();
        t_runs();
        t_extremes();
        t_done_pulse();
        t_ignore_busy();
        t_hold();
        t_back_to_back();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule